// File: doc/BRIEF.md
# Approximate Set-One Lower-Part Adder

This combinational block produces the low-order part of a wide sum without any carry logic. It is meant to sit below an accurate upper adder in a hybrid datapath. The upper adder handles the significant bits. This block gives a cheap estimate for the bits that matter least.

The block walks the two operands from the most significant bit downward. Each output bit is the exclusive-or of the two operand bits until the walk reaches the first position where both operand bits are 1. That position, and every position below it, is forced to 1 in the result.

The positions that were forced are also presented on a separate mask output, so the effect of the approximation can be observed. There is no carry-in and no carry-out. The operand width is a parameter of at least 2.

Top module: `approx_lowpart_adder`

## Requirements
- R1: When no bit position has both operand bits equal to 1, the mask output is all zeros and the sum equals the bitwise XOR of the operands.
- R2: Mask bit i is 1 exactly when some position j with j >= i has both operand bits equal to 1.
- R3: Every sum bit whose mask bit is 1 is 1.
- R4: Every sum bit whose mask bit is 0 equals the XOR of the two operand bits at that position.
- R5: If the highest position with both operand bits equal to 1 is p, the sum bits above p are the XOR of the operands and the sum bits p down to 0 are all 1.
- R6: The mask is always a run of ones that starts at bit 0, or zero; no mask bit is 1 while a lower mask bit is 0.
- R7: Once a both-ones position p exists, changing the operand bits below p has no effect on the sum or on the mask.
- R8: The outputs depend only on the present operands: the block holds no state and has no carry input or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sum | output | WIDTH | Approximate sum |
| force_mask | output | WIDTH | 1 at every position forced to 1 |

## Verification
The bound checker tests three relations on every input change: forced bits read 1, unforced bits follow the XOR, and the mask has a thermometer shape that is empty exactly when there is no both-ones position. Where the mask begins, and the fact that lower operand bits have no influence once the mask starts, are covered only by the bench. The bench walks every operand pair of a 6-bit instance against a scanning reference model. It then applies directed pairs that differ only below the stop point.

// File: rtl/approx_lowpart_adder.sv
module approx_lowpart_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] force_mask
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] both_one;
  logic [WIDTH-1:0] half_sum;

  assign both_one = a & b;
  assign half_sum = a ^ b;

  assign force_mask[TOP] = both_one[TOP];

  for (genvar i = TOP - 1; i >= 0; i--) begin : g_prefix
    assign force_mask[i] = force_mask[i+1] | both_one[i];
  end

  assign sum = half_sum | force_mask;

endmodule

module approx_lowpart_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] sum,
  input logic [WIDTH-1:0] force_mask
);

  logic [WIDTH-1:0] mask_inc;
  assign mask_inc = force_mask + WIDTH'(1);

  always_comb begin
    if (!$isunknown({a, b})) begin
      p_forced_ones_r3: assert ((sum & force_mask) == force_mask)
        else $error("forced bit not 1");
      p_free_xor_r4: assert (((sum ^ a ^ b) & ~force_mask) == '0)
        else $error("unforced bit not XOR");
      p_thermometer_r6: assert ((mask_inc & force_mask) == '0)
        else $error("mask not a low run of ones");
      p_no_hit_r1: assert (((a & b) == '0) == (force_mask == '0))
        else $error("mask emptiness disagrees with both-ones");
    end
  end

endmodule

bind approx_lowpart_adder approx_lowpart_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .sum(sum), .force_mask(force_mask)
);

// File: tb/approx_lowpart_adder_test.sv
`timescale 1ns/1ps
module approx_lowpart_adder_test;

  localparam int W = 6;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b, sum, force_mask;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  approx_lowpart_adder #(.WIDTH(W)) uut (
    .a(a), .b(b), .sum(sum), .force_mask(force_mask)
  );

  function automatic void model(input logic [W-1:0] x, input logic [W-1:0] y,
                                output logic [W-1:0] s, output logic [W-1:0] m);
    bit hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (x[i] && y[i]) hit = 1'b1;
      m[i] = hit;
      s[i] = hit ? 1'b1 : (x[i] ^ y[i]);
    end
  endfunction

  task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%b b=%b actual=%b expected=%b", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] es, em, s_ref, m_ref;
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R8 reset sum", sum, '0);
    cmp("R8 reset mask", force_mask, '0);

    for (int x = 0; x < N; x++) begin
      for (int y = 0; y < N; y++) begin
        apply(W'(x), W'(y));
        model(W'(x), W'(y), es, em);
        cmp("R2/R6 mask", force_mask, em);
        cmp("R3/R4/R5 sum", sum, es);
        if ((x & y) == 0) cmp("R1 xor", sum, W'(x ^ y));
      end
    end

    apply(6'b101101, 6'b011010);
    s_ref = sum;
    m_ref = force_mask;
    cmp("R5 stop at bit3", s_ref, 6'b111111);
    apply(6'b101000, 6'b011000);
    cmp("R7 lower bits ignored sum", sum, s_ref);
    cmp("R7 lower bits ignored mask", force_mask, m_ref);
    apply(6'b000101, 6'b000111);
    cmp("R5 stop at bit2", sum, 6'b000111);
    apply(6'b000100, 6'b000100);
    cmp("R7 below bit2 ignored", sum, 6'b000111);
    apply(6'b100000, 6'b100000);
    cmp("R5 msb both ones", sum, 6'b111111);
    apply(6'b000001, 6'b000001);
    cmp("R5 lsb only", sum, 6'b000001);
    apply(6'b101010, 6'b010101);
    cmp("R1 disjoint", force_mask, 6'b000000);
    apply(6'b000000, 6'b000000);
    cmp("R8 no state kept", sum, 6'b000000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule